// File: doc/BRIEF.md
# Radix-8 Booth Significand Multiplier

This block multiplies two 53-bit floating-point significands as unsigned integers and returns their full 106-bit product three clock cycles later. Each operand may arrive with leading zeros, as a subnormal significand does. The first stage moves each operand left until its top bit is set, and it reports the total number of positions moved so that a downstream exponent path can correct for them. The first stage also forms three times the normalized multiplicand and recodes the normalized multiplier into eighteen signed radix-8 digits.

The second stage turns each digit into a partial product taken from zero, one, two, three or four times the multiplicand, with either sign. It then reduces the eighteen rows to two with a fixed tree of 3:2 counters. The row count falls 18, 12, 8, 6, 4, 3, 2 along the tree. The third stage adds the two rows with a single carry-propagate adder. A valid bit travels with the data. A register stage loads only when valid data reaches it, so the outputs keep their last result while no new operation completes.

Top module: `sigMulR8`

## Requirements
- R1: `outValid` is high on exactly the third rising edge after a rising edge that sampled `inValid` high; the latency is three cycles.
- R2: For each valid operation, `product` equals norm(a) × norm(b) as an exact 106-bit unsigned value. norm(x) is x shifted left until bit 52 is set, and a zero operand stays zero.
- R3: `outShift` equals lz(a) + lz(b), where lz is the number of leading zeros in the 53-bit operand and lz(0) = 53.
- R4: If either operand is zero, `product` is zero.
- R5: If both operands are nonzero, bit 105 or bit 104 of `product` is set.
- R6: Every recoded multiplier digit lies in −4..+4, with a one-hot magnitude. The top digit is never negative. The result is correct for multiplier patterns that give large-magnitude digits, such as all ones.
- R7: When no valid operation completes in a cycle, `product` and `outShift` keep their previous values.
- R8: A synchronous reset, `rst` high, clears the valid pipeline. Operations in flight when reset is applied never raise `outValid`.
- R9: One operation can be accepted on every cycle, and back-to-back operations return back-to-back results in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the valid pipeline, active high |
| inValid | input | 1 | Operands on `aSig`/`bSig` are to be multiplied |
| aSig | input | 53 | Multiplicand significand, unsigned |
| bSig | input | 53 | Multiplier significand, unsigned |
| outValid | output | 1 | `product` and `outShift` hold a new result |
| product | output | 106 | Product of the normalized operands |
| outShift | output | 7 | Total left shift applied to both operands |

## Verification
The properties assume that `rst` is high from time zero until the first clock edges, and that the operands are known values whenever `inValid` is high. Checks that look three cycles back to the operands are gated by `outValid`. Because of that gate they never compare against values from before reset or against idle cycles. The stimulus drives inputs only at falling edges, holds reset during the first cycles, and keeps `inValid` low except on cycles that carry a defined operand pair. This includes the cycle in which reset is raised in the middle of an operation.

// File: rtl/sigMulR8Pkg.sv
package sigMulR8Pkg;

  // One radix-8 digit: sign plus one-hot magnitude (bit k selects (k+1) times the multiplicand)
  typedef struct packed {
    logic       neg;
    logic [3:0] mag;
  } boothDigit_t;

  // Load strobes from the control to the datapath, one per stage register
  typedef struct packed {
    logic load1;
    logic load2;
    logic load3;
  } stageEn_t;

  // Window {w3,w2,w1,w0}, weight -4*w3 + 2*w2 + w1 + w0
  function automatic boothDigit_t boothEncode(input logic [3:0] win);
    boothDigit_t d;
    int val;
    int mag;
    val = (win[0] ? 1 : 0) + (win[1] ? 1 : 0) + (win[2] ? 2 : 0) - (win[3] ? 4 : 0);
    mag = (val < 0) ? -val : val;
    d.neg = (val < 0);
    d.mag = (mag == 0) ? 4'b0000 : 4'(1 << (mag - 1));
    return d;
  endfunction

endpackage

// File: rtl/sigMulR8Ctrl.sv
module sigMulR8Ctrl
  import sigMulR8Pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  output stageEn_t en,
  output logic     outValid
);

  logic [STAGES-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[STAGES-2:0], inValid};
  end

  assign en.load1 = inValid;
  assign en.load2 = vPipe[0];
  assign en.load3 = vPipe[1];
  assign outValid = vPipe[STAGES-1];

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 3)) else $error("result without issue"); // R1

  AST_RESET_FLUSH: assert property (@(posedge clk)
    rst |=> !outValid) else $error("valid survived reset"); // R8

endmodule

// File: rtl/sigMulR8Norm.sv
module sigMulR8Norm #(
  parameter int W    = 53,
  parameter int LZ_W = $clog2(W + 1)
) (
  input  logic [W-1:0]    sigIn,
  output logic [W-1:0]    sigOut,
  output logic [LZ_W-1:0] lzCount
);

  always_comb begin
    lzCount = LZ_W'(W);
    for (int i = 0; i < W; i++) begin
      if (sigIn[i]) lzCount = LZ_W'(W - 1 - i);
    end
    sigOut = sigIn << lzCount;
  end

endmodule

// File: rtl/sigMulR8Tree.sv
module sigMulR8Tree #(
  parameter int W = 106,
  parameter int N = 18
) (
  input  logic [W-1:0] rowsIn [N],
  output logic [W-1:0] sumOut,
  output logic [W-1:0] carryOut
);

  // Each pass turns every full group of three rows into two and passes the rest through.
  always_comb begin
    logic [W-1:0] cur [N];
    logic [W-1:0] nxt [N];
    int n;
    int k;
    for (int r = 0; r < N; r++) cur[r] = rowsIn[r];
    n = N;
    for (int lv = 0; lv < N; lv++) begin
      if (n > 2) begin
        k = 0;
        for (int r = 0; r < N; r++) nxt[r] = '0;
        for (int g = 0; g < N / 3; g++) begin
          if (g < n / 3) begin
            nxt[k]     = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
            nxt[k + 1] = ((cur[3*g] & cur[3*g+1]) | (cur[3*g] & cur[3*g+2]) |
                          (cur[3*g+1] & cur[3*g+2])) << 1;
            k = k + 2;
          end
        end
        for (int r = 0; r < 2; r++) begin
          if (r < n % 3) begin
            nxt[k] = cur[3*(n/3) + r];
            k = k + 1;
          end
        end
        for (int r = 0; r < N; r++) cur[r] = nxt[r];
        n = k;
      end
    end
    sumOut   = cur[0];
    carryOut = cur[1];
  end

endmodule

// File: rtl/sigMulR8Data.sv
module sigMulR8Data
  import sigMulR8Pkg::*;
#(
  parameter int SIG_W = 53,
  localparam int PROD_W = 2 * SIG_W,
  localparam int LZ_W   = $clog2(SIG_W + 1),
  localparam int SH_W   = LZ_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  stageEn_t          en,
  input  logic [SIG_W-1:0]  aSig,
  input  logic [SIG_W-1:0]  bSig,
  output logic [PROD_W-1:0] product,
  output logic [SH_W-1:0]   outShift
);

  localparam int DIGITS = (SIG_W + 3) / 3;
  localparam int EXT_W  = 3 * DIGITS + 1;
  localparam int TRI_W  = SIG_W + 2;

  // ---------------- stage 1: normalize, triple, recode ----------------
  logic [SIG_W-1:0] aNorm, bNorm;
  logic [LZ_W-1:0]  lzA, lzB;
  logic [TRI_W-1:0] tripleD;
  logic [EXT_W-1:0] yExt;
  boothDigit_t      digitD [DIGITS];

  sigMulR8Norm #(.W(SIG_W), .LZ_W(LZ_W)) uNormA (.sigIn(aSig), .sigOut(aNorm), .lzCount(lzA));
  sigMulR8Norm #(.W(SIG_W), .LZ_W(LZ_W)) uNormB (.sigIn(bSig), .sigOut(bNorm), .lzCount(lzB));

  assign tripleD = TRI_W'(aNorm) + TRI_W'({aNorm, 1'b0});
  assign yExt    = EXT_W'({bNorm, 1'b0});

  for (genvar i = 0; i < DIGITS; i++) begin : gEnc
    assign digitD[i] = boothEncode(yExt[3*i+3 -: 4]);
  end

  logic [SIG_W-1:0] aNormQ;
  logic [TRI_W-1:0] tripleQ;
  boothDigit_t      digitQ [DIGITS];
  logic [SH_W-1:0]  shift1Q;

  always_ff @(posedge clk) begin
    if (en.load1) begin
      aNormQ  <= aNorm;
      tripleQ <= tripleD;
      digitQ  <= digitD;
      shift1Q <= SH_W'(lzA) + SH_W'(lzB);
    end
  end

  // ---------------- stage 2: select rows, compress ----------------
  logic [PROD_W-1:0] ppRow [DIGITS];

  for (genvar i = 0; i < DIGITS; i++) begin : gRow
    logic [PROD_W-1:0] mult;
    logic [PROD_W-1:0] shaped;
    always_comb begin
      mult = ({PROD_W{digitQ[i].mag[0]}} & PROD_W'(aNormQ))
           | ({PROD_W{digitQ[i].mag[1]}} & PROD_W'({aNormQ, 1'b0}))
           | ({PROD_W{digitQ[i].mag[2]}} & PROD_W'(tripleQ))
           | ({PROD_W{digitQ[i].mag[3]}} & PROD_W'({aNormQ, 2'b00}));
    end
    // negative row: inverted multiple here, its +1 rides in the next row's empty low bits
    assign shaped = digitQ[i].neg ? ((~mult) << (3*i)) : (mult << (3*i));
    if (i == 0) begin : gFirst
      assign ppRow[i] = shaped;
    end else begin : gRest
      assign ppRow[i] = shaped | (PROD_W'(digitQ[i-1].neg) << (3*(i-1)));
    end

    AST_DIGIT_SHAPE: assert property (@(posedge clk) disable iff (rst)
      en.load2 |-> ($onehot0(digitQ[i].mag) && (!digitQ[i].neg || digitQ[i].mag != 4'b0000)))
      else $error("bad recoded digit"); // R6
  end

  logic [PROD_W-1:0] sumD, carryD;

  sigMulR8Tree #(.W(PROD_W), .N(DIGITS)) uTree (
    .rowsIn  (ppRow),
    .sumOut  (sumD),
    .carryOut(carryD)
  );

  logic [PROD_W-1:0] sumQ, carryQ;
  logic [SH_W-1:0]   shift2Q;

  always_ff @(posedge clk) begin
    if (en.load2) begin
      sumQ    <= sumD;
      carryQ  <= carryD;
      shift2Q <= shift1Q;
    end
  end

  // ---------------- stage 3: carry-propagate add ----------------
  logic [PROD_W-1:0] productQ;
  logic [SH_W-1:0]   shift3Q;

  always_ff @(posedge clk) begin
    if (en.load3) begin
      productQ <= sumQ + carryQ;
      shift3Q  <= shift2Q;
    end
  end

  assign product  = productQ;
  assign outShift = shift3Q;

  AST_NORM_MSB: assert property (@(posedge clk) disable iff (rst)
    (en.load2 && aNormQ != '0) |-> aNormQ[SIG_W-1]) else $error("multiplicand not normalized"); // R2

  AST_TOP_DIGIT_POS: assert property (@(posedge clk) disable iff (rst)
    en.load2 |-> !digitQ[DIGITS-1].neg) else $error("top digit negative"); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en.load3 ##1 !en.load3) |=> ($stable(productQ) && $stable(shift3Q))) else $error("result moved while idle"); // R7

endmodule

// File: rtl/sigMulR8.sv
module sigMulR8
  import sigMulR8Pkg::*;
#(
  parameter int SIG_W = 53,
  localparam int PROD_W = 2 * SIG_W,
  localparam int SH_W   = $clog2(SIG_W + 1) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [SIG_W-1:0]  aSig,
  input  logic [SIG_W-1:0]  bSig,
  output logic              outValid,
  output logic [PROD_W-1:0] product,
  output logic [SH_W-1:0]   outShift
);

  stageEn_t en;

  sigMulR8Ctrl #(.STAGES(3)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .en      (en),
    .outValid(outValid)
  );

  sigMulR8Data #(.SIG_W(SIG_W)) uData (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .aSig    (aSig),
    .bSig    (bSig),
    .product (product),
    .outShift(outShift)
  );

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(aSig == '0 || bSig == '0, 3)) |-> product == '0) else $error("zero operand, nonzero product"); // R4

  AST_PRODUCT_TOP: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(aSig != '0 && bSig != '0, 3)) |-> (product[PROD_W-1] || product[PROD_W-2]))
    else $error("product top bits clear"); // R5

endmodule

// File: tb/sigMulR8_test.sv
`timescale 1ns/1ps
module sigMulR8_test;

  localparam int W  = 53;
  localparam int PW = 2 * W;
  localparam int NV = 10;

  localparam logic [W-1:0] VEC_A [NV] = '{
    53'h1FFFFFFFFFFFFF, 53'h1, 53'h10000000000000, 53'h0, 53'h5,
    53'h15555555555555, 53'hFFF, 53'h0, 53'h1FFFFFFFFFFFFE, 53'h123456789ABC};
  localparam logic [W-1:0] VEC_B [NV] = '{
    53'h1FFFFFFFFFFFFF, 53'h1, 53'h10000000000000, 53'h1FFFFFFFFFFFFF, 53'h3,
    53'h0AAAAAAAAAAAAA, 53'h100000000, 53'h0, 53'h10000000000001, 53'h1B7};
  localparam int VEC_SH [NV] = '{0, 104, 0, 53, 101, 1, 61, 106, 0, 52};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [W-1:0]  aSig = '0;
  logic [W-1:0]  bSig = '0;
  logic          outValid;
  logic [PW-1:0] product;
  logic [6:0]    outShift;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sigMulR8 uut (
    .clk(clk), .rst(rst), .inValid(inValid), .aSig(aSig), .bSig(bSig),
    .outValid(outValid), .product(product), .outShift(outShift)
  );

  function automatic logic [W-1:0] refNorm(input logic [W-1:0] x);
    logic [W-1:0] v;
    v = x;
    for (int i = 0; i < W; i++) if (v != '0 && !v[W-1]) v = v << 1;
    return v;
  endfunction

  function automatic logic [PW-1:0] refProd(input logic [W-1:0] a, input logic [W-1:0] b);
    return PW'(refNorm(a)) * PW'(refNorm(b));
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(20000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] heldP;
    logic [6:0]    heldS;

    repeat (3) @(negedge clk);
    check("R8 reset state outValid", 128'(outValid), 128'(0));
    rst = 1'b0;

    // table walk, one operation per cycle (R9)
    for (int c = 0; c < NV + 3; c++) begin
      @(negedge clk);
      if (c >= 3) begin
        check("R9 R1 streamed outValid", 128'(outValid), 128'(1));
        check("R2 R6 product", 128'(product), 128'(refProd(VEC_A[c-3], VEC_B[c-3])));
        check("R3 shift", 128'(outShift), 128'(VEC_SH[c-3]));
        if (VEC_A[c-3] == '0 || VEC_B[c-3] == '0)
          check("R4 zero operand", 128'(product), 128'(0));
        else
          check("R5 product top", 128'(product[PW-1] | product[PW-2]), 128'(1));
      end
      if (c < NV) begin
        inValid = 1'b1; aSig = VEC_A[c]; bSig = VEC_B[c];
      end else begin
        inValid = 1'b0; aSig = 53'h1F0F0F0F0F0F0F; bSig = 53'h1;
      end
    end

    // idle cycles: outputs hold
    heldP = product;
    heldS = outShift;
    for (int d = 0; d < 3; d++) begin
      @(negedge clk);
      check("R1 idle outValid", 128'(outValid), 128'(0));
      check("R7 product held", 128'(product), 128'(heldP));
      check("R7 shift held", 128'(outShift), 128'(heldS));
    end

    // isolated issue, exact latency
    @(negedge clk);
    inValid = 1'b1; aSig = 53'h3; bSig = 53'h7;
    for (int d = 1; d <= 3; d++) begin
      @(negedge clk);
      inValid = 1'b0;
      check("R1 latency", 128'(outValid), 128'(d == 3));
    end
    check("R2 isolated product", 128'(product), 128'(refProd(53'h3, 53'h7)));
    check("R3 isolated shift", 128'(outShift), 128'(50 + 51));

    // alternating-sign digits in the multiplier
    @(negedge clk);
    inValid = 1'b1; aSig = 53'h1ABCDEF0123457; bSig = 53'h1C71C71C71C71C;
    @(negedge clk);
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 mixed digits", 128'(product), 128'(refProd(53'h1ABCDEF0123457, 53'h1C71C71C71C71C)));

    // reset while an operation is in flight
    @(negedge clk);
    inValid = 1'b1; aSig = 53'h1234; bSig = 53'h5678;
    @(negedge clk);
    inValid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int d = 0; d < 3; d++) begin
      @(negedge clk);
      check("R8 flushed", 128'(outValid), 128'(0));
    end

    // zero multiplier with a full multiplicand
    @(negedge clk);
    inValid = 1'b1; aSig = 53'h1FFFFFFFFFFFFF; bSig = 53'h0;
    @(negedge clk);
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 zero multiplier valid", 128'(outValid), 128'(1));
    check("R4 zero multiplier product", 128'(product), 128'(0));
    check("R3 zero multiplier shift", 128'(outShift), 128'(53));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule